// File: doc/BRIEF.md
# Register File with Delayed Load Commit

This block is the general-purpose register store of a small 32-bit CPU core. It holds 32 registers of 32 bits, a program counter, and the two multiply/divide result registers (high and low halves). It also carries the architectural load delay inside the register file. Data returned by a load is not written to its register at once. It waits in an "issued" slot, then in a "committing" slot. Each step strobe moves it forward one place.

Two read ports each give two views of the addressed register. The plain view returns what the storage array holds, which is the old value while a load to that register is still committing. The forwarded view substitutes the committing data. A direct write, or a newly issued load, that names the register held in the committing slot cancels that pending entry, so the later update wins. A flush strobe drains both slots into the array in one cycle.

Top module: `lrf_regfile`

## Requirements
- R1: Register index 0 always reads 0 on both plain and forwarded outputs, and any write or committed load to index 0 is discarded.
- R2: A synchronous active-high reset sets the program counter to 0xBFC00000, sets high, low and every general register to 0, empties both pending slots and clears the overrun flag.
- R3: A delayed load request places its (index, data) pair in the issued slot. On each step strobe, a valid committing entry is written to the array, the issued entry moves to the committing slot, and the issued slot becomes empty.
- R4: A direct write that names the index held in the committing slot cancels that entry. When a step and a direct write fall in the same cycle, the step's commit is applied first and the direct write wins on an index clash.
- R5: Issuing a delayed load whose index equals the committing entry's index cancels the committing entry.
- R6: The plain read returns the array contents. The forwarded read returns the committing data when that slot is valid and its index equals the read index (index 0 excepted), and otherwise returns the array contents.
- R7: A flush has the effect of two steps in one cycle. The committing entry and then the issued entry are written to the array, so the issued entry wins on the same index, and both slots end empty.
- R8: A delayed load requested while the issued slot stays occupied through that cycle (no step or flush) is dropped, and the overrun flag goes to 1 and stays at 1 until reset.
- R9: A step and a delayed load request in the same cycle are legal. The old issued entry moves to committing and the new entry lands in the issued slot.
- R10: The program counter, high and low registers each load their own write data on their own write enable, visible on the next cycle. They are otherwise unchanged.
- R11: Both read ports are combinational. A change of read index shows on the outputs in the same cycle, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_adv | input | 1 | Moves the pending loads one place |
| step_flush | input | 1 | Drains both pending slots into the array |
| wr_en | input | 1 | Direct write enable |
| wr_idx | input | 5 | Direct write register index |
| wr_data | input | 32 | Direct write data |
| ld_en | input | 1 | Delayed load request |
| ld_idx | input | 5 | Delayed load register index |
| ld_data | input | 32 | Delayed load data |
| rd_a_idx | input | 5 | Read port A index |
| rd_b_idx | input | 5 | Read port B index |
| rd_a_plain | output | 32 | Port A array value |
| rd_a_fwd | output | 32 | Port A value with committing data forwarded |
| rd_b_plain | output | 32 | Port B array value |
| rd_b_fwd | output | 32 | Port B value with committing data forwarded |
| pc_we | input | 1 | Program counter write enable |
| pc_wdata | input | 32 | Program counter write data |
| hi_we | input | 1 | High register write enable |
| hi_wdata | input | 32 | High register write data |
| lo_we | input | 1 | Low register write enable |
| lo_wdata | input | 32 | Low register write data |
| pc_q | output | 32 | Program counter |
| hi_q | output | 32 | High register |
| lo_q | output | 32 | Low register |
| ld_overrun | output | 1 | Sticky flag for a dropped delayed load |

## Verification
The collisions that matter are a step arriving in the same cycle as a direct write or as a new delayed load, where ordering decides which value reaches the register. Directed sequences place a load in the committing slot and then pulse a step together with a write to the same index, or together with a new load request. The array value and the forwarded value are read before and after that edge. A random phase restricts indices to four registers, so that step, flush, direct write and load requests pile onto the same index. The behavioural model in the bench judges every read, special-register and flag output on each clock.

// File: rtl/lrf_pkg.sv
package lrf_pkg;

    localparam int LRF_XLEN = 32;
    localparam int LRF_NREG = 32;
    localparam int LRF_IDXW = $clog2(LRF_NREG);
    localparam logic [LRF_XLEN-1:0] LRF_BOOT_PC = 32'hBFC0_0000;

    typedef logic [LRF_XLEN-1:0] word_t;
    typedef logic [LRF_IDXW-1:0] idx_t;

    // one pending delayed-load entry
    typedef struct packed {
        logic  vld;
        idx_t  idx;
        word_t data;
    } ld_ent_t;

    // one write into the register array
    typedef struct packed {
        logic  en;
        idx_t  idx;
        word_t data;
    } wport_t;

    function automatic logic ent_hit(ld_ent_t e, idx_t i);
        return e.vld && (e.idx == i);
    endfunction

    function automatic wport_t ent_to_wport(ld_ent_t e, logic go);
        wport_t w;
        w.en   = go && e.vld;
        w.idx  = e.idx;
        w.data = e.data;
        return w;
    endfunction

endpackage

// File: rtl/lrf_pending.sv
module lrf_pending
    import lrf_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    step_adv,
    input  logic    step_flush,
    input  logic    wr_en,
    input  idx_t    wr_idx,
    input  ld_ent_t ld_req,
    output wport_t  commit_old,
    output wport_t  commit_new,
    output ld_ent_t com_q,
    output logic    overrun_q
);

    ld_ent_t iss_q;
    ld_ent_t iss_mid, com_mid;
    ld_ent_t iss_d, com_d;
    logic    step_any, ld_ok, ld_bad;

    always_comb begin
        step_any = step_adv || step_flush;

        // committing entry always drains on a step; issued one drains too on flush
        commit_old = ent_to_wport(com_q, step_any);
        commit_new = ent_to_wport(iss_q, step_flush);

        // slot contents after the step
        iss_mid = iss_q;
        com_mid = com_q;
        if (step_any) begin
            iss_mid = '0;
            com_mid = step_flush ? '0 : iss_q;
        end

        ld_ok  = ld_req.vld && !iss_mid.vld;
        ld_bad = ld_req.vld &&  iss_mid.vld;

        // later writers cancel a clashing committing entry
        com_d = com_mid;
        if (wr_en && ent_hit(com_mid, wr_idx))
            com_d.vld = 1'b0;
        if (ld_ok && ent_hit(com_mid, ld_req.idx))
            com_d.vld = 1'b0;

        iss_d = ld_ok ? ld_req : iss_mid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            iss_q     <= '0;
            com_q     <= '0;
            overrun_q <= 1'b0;
        end else begin
            iss_q     <= iss_d;
            com_q     <= com_d;
            overrun_q <= overrun_q || ld_bad;
        end
    end

    AST_STEP_EMPTIES_ISSUED: assert property (@(posedge clk) disable iff (rst)
        (step_adv || step_flush) && !ld_req.vld |=> !iss_q.vld); // R3
    AST_FLUSH_DRAINS_ALL: assert property (@(posedge clk) disable iff (rst)
        step_flush |=> !com_q.vld); // R7
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        overrun_q |=> overrun_q); // R8
    AST_OVERRUN_DROPS: assert property (@(posedge clk) disable iff (rst)
        ld_req.vld && iss_q.vld && !step_adv && !step_flush |=> $stable(iss_q) && overrun_q); // R8
    AST_WRITE_CANCELS: assert property (@(posedge clk) disable iff (rst)
        wr_en && !step_adv && !step_flush && ent_hit(com_q, wr_idx) |=> !com_q.vld); // R4
    AST_LOAD_CANCELS: assert property (@(posedge clk) disable iff (rst)
        ld_req.vld && !iss_q.vld && !step_adv && !step_flush && ent_hit(com_q, ld_req.idx)
        |=> !com_q.vld); // R5
    AST_STEP_WITH_LOAD: assert property (@(posedge clk) disable iff (rst)
        step_adv && !step_flush && ld_req.vld |=> iss_q.vld && !overrun_q == !$past(overrun_q)); // R9

endmodule

// File: rtl/lrf_gpr_array.sv
module lrf_gpr_array
    import lrf_pkg::*;
#(
    parameter int NWP = 3,
    parameter int NRP = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  wport_t wp [NWP],
    input  idx_t   rd_idx [NRP],
    output word_t  rd_val [NRP]
);

    word_t mem [LRF_NREG];

    // later port index wins when two ports name the same register
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < LRF_NREG; r++)
                mem[r] <= '0;
        end else begin
            for (int p = 0; p < NWP; p++)
                if (wp[p].en && (wp[p].idx != '0))
                    mem[wp[p].idx] <= wp[p].data;
        end
    end

    for (genvar g = 0; g < NRP; g++) begin : g_rd
        assign rd_val[g] = (rd_idx[g] == '0) ? '0 : mem[rd_idx[g]];

        always @(posedge clk) begin
            if (!rst && rd_idx[g] == '0)
                AST_ZERO_READS_ZERO: assert (rd_val[g] == '0); // R1
        end
    end

endmodule

// File: rtl/lrf_spec_regs.sv
module lrf_spec_regs
    import lrf_pkg::*;
#(
    parameter word_t BOOT_PC = LRF_BOOT_PC
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  pc_we,
    input  word_t pc_wdata,
    input  logic  hi_we,
    input  word_t hi_wdata,
    input  logic  lo_we,
    input  word_t lo_wdata,
    output word_t pc_q,
    output word_t hi_q,
    output word_t lo_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= BOOT_PC;
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            if (pc_we) pc_q <= pc_wdata;
            if (hi_we) hi_q <= hi_wdata;
            if (lo_we) lo_q <= lo_wdata;
        end
    end

    AST_HI_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !hi_we |=> $stable(hi_q)); // R10
    AST_PC_LOADS: assert property (@(posedge clk) disable iff (rst)
        pc_we |=> pc_q == $past(pc_wdata)); // R10

endmodule

// File: rtl/lrf_regfile.sv
module lrf_regfile
    import lrf_pkg::*;
#(
    parameter logic [LRF_XLEN-1:0] BOOT_PC = LRF_BOOT_PC
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                step_adv,
    input  logic                step_flush,
    input  logic                wr_en,
    input  logic [LRF_IDXW-1:0] wr_idx,
    input  logic [LRF_XLEN-1:0] wr_data,
    input  logic                ld_en,
    input  logic [LRF_IDXW-1:0] ld_idx,
    input  logic [LRF_XLEN-1:0] ld_data,
    input  logic [LRF_IDXW-1:0] rd_a_idx,
    input  logic [LRF_IDXW-1:0] rd_b_idx,
    output logic [LRF_XLEN-1:0] rd_a_plain,
    output logic [LRF_XLEN-1:0] rd_a_fwd,
    output logic [LRF_XLEN-1:0] rd_b_plain,
    output logic [LRF_XLEN-1:0] rd_b_fwd,
    input  logic                pc_we,
    input  logic [LRF_XLEN-1:0] pc_wdata,
    input  logic                hi_we,
    input  logic [LRF_XLEN-1:0] hi_wdata,
    input  logic                lo_we,
    input  logic [LRF_XLEN-1:0] lo_wdata,
    output logic [LRF_XLEN-1:0] pc_q,
    output logic [LRF_XLEN-1:0] hi_q,
    output logic [LRF_XLEN-1:0] lo_q,
    output logic                ld_overrun
);

    localparam int NRP = 2;
    localparam int NWP = 3;

    ld_ent_t ld_req, com_q;
    wport_t  commit_old, commit_new, direct_w;
    wport_t  wp [NWP];
    idx_t    rd_idx [NRP];
    word_t   plain [NRP];
    word_t   fwd [NRP];

    assign ld_req   = '{vld: ld_en, idx: ld_idx, data: ld_data};
    assign direct_w = '{en: wr_en, idx: wr_idx, data: wr_data};

    // array priority: committing < issued (flush) < direct write
    assign wp[0] = commit_old;
    assign wp[1] = commit_new;
    assign wp[2] = direct_w;

    lrf_pending u_pend (
        .clk        (clk),
        .rst        (rst),
        .step_adv   (step_adv),
        .step_flush (step_flush),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .ld_req     (ld_req),
        .commit_old (commit_old),
        .commit_new (commit_new),
        .com_q      (com_q),
        .overrun_q  (ld_overrun)
    );

    lrf_gpr_array #(.NWP(NWP), .NRP(NRP)) u_gpr (
        .clk    (clk),
        .rst    (rst),
        .wp     (wp),
        .rd_idx (rd_idx),
        .rd_val (plain)
    );

    lrf_spec_regs #(.BOOT_PC(BOOT_PC)) u_spec (
        .clk      (clk),
        .rst      (rst),
        .pc_we    (pc_we),
        .pc_wdata (pc_wdata),
        .hi_we    (hi_we),
        .hi_wdata (hi_wdata),
        .lo_we    (lo_we),
        .lo_wdata (lo_wdata),
        .pc_q     (pc_q),
        .hi_q     (hi_q),
        .lo_q     (lo_q)
    );

    assign rd_idx[0] = rd_a_idx;
    assign rd_idx[1] = rd_b_idx;

    for (genvar g = 0; g < NRP; g++) begin : g_fwd
        assign fwd[g] = (ent_hit(com_q, rd_idx[g]) && rd_idx[g] != '0) ? com_q.data : plain[g];

        always @(posedge clk) begin
            if (!rst && !com_q.vld)
                AST_FWD_EQ_PLAIN_IDLE: assert (fwd[g] == plain[g]); // R6
        end
    end

    assign rd_a_plain = plain[0];
    assign rd_a_fwd   = fwd[0];
    assign rd_b_plain = plain[1];
    assign rd_b_fwd   = fwd[1];

endmodule

// File: tb/lrf_regfile_tb.sv
module lrf_regfile_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_adv = 0, step_flush = 0;
    logic        wr_en = 0, ld_en = 0;
    logic [4:0]  wr_idx = 0, ld_idx = 0, rd_a_idx = 0, rd_b_idx = 0;
    logic [31:0] wr_data = 0, ld_data = 0;
    logic        pc_we = 0, hi_we = 0, lo_we = 0;
    logic [31:0] pc_wdata = 0, hi_wdata = 0, lo_wdata = 0;
    logic [31:0] rd_a_plain, rd_a_fwd, rd_b_plain, rd_b_fwd, pc_q, hi_q, lo_q;
    logic        ld_overrun;

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    int unsigned m_gpr [32];
    bit          m_iv, m_cv, m_err;
    int          m_ii, m_ci;
    int unsigned m_id, m_cd, m_pc, m_hi, m_lo;

    always #4 clk = ~clk;

    lrf_regfile dut_i (
        .clk(clk), .rst(rst), .step_adv(step_adv), .step_flush(step_flush),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
        .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
        .rd_a_plain(rd_a_plain), .rd_a_fwd(rd_a_fwd),
        .rd_b_plain(rd_b_plain), .rd_b_fwd(rd_b_fwd),
        .pc_we(pc_we), .pc_wdata(pc_wdata), .hi_we(hi_we), .hi_wdata(hi_wdata),
        .lo_we(lo_we), .lo_wdata(lo_wdata),
        .pc_q(pc_q), .hi_q(hi_q), .lo_q(lo_q), .ld_overrun(ld_overrun)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int unsigned m_plain(int i);
        return (i == 0) ? 0 : m_gpr[i];
    endfunction

    function automatic int unsigned m_fwd(int i);
        if (m_cv && m_ci == i && i != 0) return m_cd;
        return m_plain(i);
    endfunction

    task automatic m_put(int i, int unsigned d);
        if (i != 0) m_gpr[i] = d;
    endtask

    task automatic model_step();
        if (rst) begin
            foreach (m_gpr[k]) m_gpr[k] = 0;
            m_iv = 0; m_cv = 0; m_err = 0;
            m_pc = 32'hBFC0_0000; m_hi = 0; m_lo = 0;
            return;
        end
        if (step_adv || step_flush) begin
            if (m_cv) m_put(m_ci, m_cd);
            if (step_flush) begin
                if (m_iv) m_put(m_ii, m_id);
                m_cv = 0;
            end else begin
                m_cv = m_iv; m_ci = m_ii; m_cd = m_id;
            end
            m_iv = 0;
        end
        if (wr_en) begin
            m_put(wr_idx, wr_data);
            if (m_cv && m_ci == wr_idx) m_cv = 0;
        end
        if (ld_en) begin
            if (m_iv) m_err = 1;
            else begin
                if (m_cv && m_ci == ld_idx) m_cv = 0;
                m_iv = 1; m_ii = ld_idx; m_id = ld_data;
            end
        end
        if (pc_we) m_pc = pc_wdata;
        if (hi_we) m_hi = hi_wdata;
        if (lo_we) m_lo = lo_wdata;
    endtask

    // compare, clock, update model, release strobes
    task automatic tick();
        #1;
        if (!rst) begin
            chk("R6 plain a", rd_a_plain, m_plain(rd_a_idx));
            chk("R6 fwd a",   rd_a_fwd,   m_fwd(rd_a_idx));
            chk("R6 plain b", rd_b_plain, m_plain(rd_b_idx));
            chk("R6 fwd b",   rd_b_fwd,   m_fwd(rd_b_idx));
            chk("R10 pc",     pc_q, m_pc);
            chk("R10 hi",     hi_q, m_hi);
            chk("R10 lo",     lo_q, m_lo);
            chk("R8 flag",    {31'd0, ld_overrun}, {31'd0, m_err});
        end
        @(posedge clk);
        model_step();
        @(negedge clk);
        step_adv = 0; step_flush = 0; wr_en = 0; ld_en = 0;
        pc_we = 0; hi_we = 0; lo_we = 0;
    endtask

    task automatic do_ld(int i, int unsigned d);
        ld_en = 1; ld_idx = 5'(i); ld_data = d;
    endtask

    task automatic do_wr(int i, int unsigned d);
        wr_en = 1; wr_idx = 5'(i); wr_data = d;
    endtask

    task automatic look(string req, int i, int unsigned ep, int unsigned ef);
        rd_a_idx = 5'(i);
        #1;
        chk(req, rd_a_plain, ep);
        chk(req, rd_a_fwd, ef);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        tick(); tick();
        rst = 0;
        // R2 reset state
        chk("R2 pc", pc_q, 32'hBFC0_0000);
        chk("R2 hi", hi_q, 0);
        chk("R2 lo", lo_q, 0);
        chk("R2 flag", {31'd0, ld_overrun}, 0);
        look("R2 gpr", 5, 0, 0);

        // R11 combinational read
        do_wr(5, 32'h11); tick();
        rd_b_idx = 0;
        look("R11 read", 5, 32'h11, 32'h11);
        chk("R11 port b", rd_b_plain, 0);

        // R1 index zero
        do_wr(0, 32'hFFFF); tick();
        look("R1 zero", 0, 0, 0);
        do_ld(0, 32'h77); tick(); step_adv = 1; tick();
        look("R1 zero fwd", 0, 0, 0);
        step_adv = 1; tick();

        // R3 two steps
        do_ld(6, 32'hAA); tick();
        look("R3 issued", 6, 0, 0);
        step_adv = 1; tick();
        look("R3 committing", 6, 0, 32'hAA);
        step_adv = 1; tick();
        look("R3 landed", 6, 32'hAA, 32'hAA);

        // R4 direct write cancels committing
        do_ld(7, 1); tick(); step_adv = 1; tick();
        do_wr(7, 2); tick();
        look("R4 cancel", 7, 2, 2);
        step_adv = 1; tick();
        look("R4 after step", 7, 2, 2);
        // R4 same-cycle step and write
        do_ld(8, 3); tick(); step_adv = 1; tick();
        step_adv = 1; do_wr(8, 4); tick();
        look("R4 same cycle", 8, 4, 4);

        // R5 new load cancels committing
        do_ld(9, 5); tick(); step_adv = 1; tick();
        do_ld(9, 6); tick();
        look("R5 cancelled", 9, 0, 0);
        step_adv = 1; tick();
        look("R5 second load", 9, 0, 6);
        step_adv = 1; tick();
        look("R5 landed", 9, 6, 6);

        // R7 flush
        do_ld(10, 7); tick(); step_adv = 1; tick();
        do_ld(10, 8); tick();
        step_flush = 1; tick();
        look("R7 flush", 10, 8, 8);

        // R9 step with issue
        do_ld(13, 9); tick();
        step_adv = 1; do_ld(14, 32'hA); tick();
        chk("R9 no flag", {31'd0, ld_overrun}, 0);
        look("R9 old moved", 13, 0, 9);
        step_adv = 1; tick();
        look("R9 new moved", 14, 0, 32'hA);
        step_adv = 1; tick();
        look("R9 landed", 14, 32'hA, 32'hA);

        // R8 overrun
        do_ld(11, 1); tick();
        do_ld(12, 2); tick();
        chk("R8 flag set", {31'd0, ld_overrun}, 1);
        step_adv = 1; tick(); step_adv = 1; tick();
        look("R8 kept", 11, 1, 1);
        look("R8 dropped", 12, 0, 0);
        tick();
        chk("R8 sticky", {31'd0, ld_overrun}, 1);

        // R10 special registers
        pc_we = 1; pc_wdata = 32'h1000; tick();
        chk("R10 pc load", pc_q, 32'h1000);
        chk("R10 hi idle", hi_q, 0);
        hi_we = 1; hi_wdata = 32'h22; tick();
        chk("R10 hi load", hi_q, 32'h22);
        chk("R10 pc hold", pc_q, 32'h1000);
        lo_we = 1; lo_wdata = 32'h33; tick();
        chk("R10 lo load", lo_q, 32'h33);

        // random clash phase, flag cleared first
        rst = 1; tick(); rst = 0;
        for (int n = 0; n < 600; n++) begin
            step_adv   = ($urandom_range(0, 2) == 0);
            step_flush = ($urandom_range(0, 9) == 0);
            if ($urandom_range(0, 2) == 0) do_wr($urandom_range(0, 3), $urandom);
            if ($urandom_range(0, 1) == 0) do_ld($urandom_range(0, 3), $urandom);
            hi_we = ($urandom_range(0, 4) == 0); hi_wdata = $urandom;
            rd_a_idx = 5'($urandom_range(0, 3));
            rd_b_idx = 5'($urandom_range(0, 3));
            tick();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule